// File: doc/BRIEF.md
# Time-Shared Two-Port Word Memory

This block gives a synchronous two-port view of a storage array that has only one access path. Each clock cycle it can take one read request and one write request, each with its own address, and it completes both inside that same cycle. It does this by running a read phase in the first half of the cycle and a write phase in the second half. An address multiplexer steers the read address or the write address onto the single decode path, depending on the phase.

All requests, addresses and write data are captured at the rising edge. Read data goes into an output holding register, which keeps the last value read until a later read replaces it. The word address is split three ways. The low 7 bits pick one of 128 rows. The next 2 bits pick one of four 128-word columns. The remaining bits pick one 512-word bank. Only the addressed bank is enabled, and every other bank stays idle.

The word count is a parameter, set to a multiple of 128 up to 4096. The word width is a parameter, set to a multiple of 9 bits. If the word count is not a power of two, some addresses fall outside the memory. Writes to those addresses are dropped, and reads from them return zero.

Top module: `tsdp_mem`

## Requirements
- R1: Requests, addresses and write data are sampled at the rising clock edge. Input changes after that edge do not affect the access that edge started. Read data for a read sampled at edge k is on `rd_data` by the falling edge that follows, and it is still valid just before edge k+1.
- R2: A read and a write sampled at the same edge both complete before the next rising edge.
- R3: Within a cycle the read phase comes first and the write phase second. A read and a write to the same address in one cycle return the old word. A read in a later cycle returns the new word.
- R4: `rd_data` keeps its value through any cycle that has no read request, including cycles that only write.
- R5: The address splits into row = bits [6:0], column = bits [8:7] and bank = bits above 8. Every in-range address holds its own word, independent of all others.
- R6: At most one bank is enabled during any phase, and it is the bank that the phase's address selects.
- R7: With no request in a phase, no bank is enabled.
- R8: A write to an address at or above the word count changes no stored word.
- R9: A read from an address at or above the word count loads zero into `rd_data`.
- R10: While reset is asserted, and directly after it, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The rising edge samples inputs; the falling edge separates the read and write phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 9*LANES | Write word |
| rd_data | output | 9*LANES | Held read word |

## Verification
A fault in the phase sequencer or in the address multiplexer shows up in the same cycle. The read-before-write order breaks, so a same-address read returns the new word instead of the old one, or the write lands on the read address. A fault in the field split or in the bank enables aliases two addresses. This is only seen when the aliased word is read back later, so a full fill followed by a full readback exposes it within one pass over the memory. A holding-register fault changes `rd_data` in a cycle without a read, and the next sample shows it.

// File: rtl/tsdp_pkg.sv
package tsdp_pkg;
  localparam int unsigned ROWS       = 128;
  localparam int unsigned COLS       = 4;
  localparam int unsigned BANK_WORDS = ROWS * COLS;
  localparam int unsigned LANE_BITS  = 9;
  localparam int unsigned ROW_W      = 7;
  localparam int unsigned COL_W      = 2;

  function automatic int unsigned row_of(input int unsigned a);
    return a % ROWS;
  endfunction

  function automatic int unsigned col_of(input int unsigned a);
    return (a / ROWS) % COLS;
  endfunction

  function automatic int unsigned bank_of(input int unsigned a);
    return a / BANK_WORDS;
  endfunction

  function automatic int unsigned bank_depth(input int unsigned words, input int unsigned b);
    return (words - b * BANK_WORDS >= BANK_WORDS) ? BANK_WORDS : words - b * BANK_WORDS;
  endfunction
endpackage

// File: rtl/tsdp_seq.sv
module tsdp_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              phase_rd,
  output logic              phase_wr,
  output logic [ADDR_W-1:0] acc_addr
);
  // pos_tgl flips at each rising edge; neg_tgl follows it at the falling edge.
  // They differ only in the first half of a cycle.
  logic pos_tgl, neg_tgl, first_half;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pos_tgl <= 1'b0;
    else        pos_tgl <= ~pos_tgl;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) neg_tgl <= 1'b0;
    else        neg_tgl <= pos_tgl;

  assign first_half = pos_tgl ^ neg_tgl;
  assign phase_rd   = rd_req & first_half;
  assign phase_wr   = wr_req & ~first_half;
  assign acc_addr   = phase_wr ? wr_addr : rd_addr;

  // R3: the write phase owns the end of the cycle
  p_wr_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (phase_wr && !phase_rd));
  // R3: the read phase owns the start of the cycle
  p_rd_first_r3: assert property (@(negedge clk) disable iff (!rst_n)
    rd_req |-> (phase_rd && !phase_wr));
endmodule

// File: rtl/tsdp_decode.sv
module tsdp_decode #(
  parameter int WORDS  = 1152,
  parameter int ADDR_W = 11,
  parameter int BANKS  = 3
) (
  input  logic                         active,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         hit,
  output logic [BANKS-1:0]             bank_en,
  output logic [tsdp_pkg::ROW_W-1:0]   row,
  output logic [tsdp_pkg::COL_W-1:0]   col
);
  logic [31:0] a32;
  assign a32 = 32'(addr);
  assign hit = a32 < 32'(WORDS);
  assign row = tsdp_pkg::ROW_W'(tsdp_pkg::row_of(a32));
  assign col = tsdp_pkg::COL_W'(tsdp_pkg::col_of(a32));

  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign bank_en[b] = active && hit && (tsdp_pkg::bank_of(a32) == 32'(b));
  end
endmodule

// File: rtl/tsdp_bank.sv
module tsdp_bank #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       we,
  input  logic [tsdp_pkg::COL_W-1:0] col,
  input  logic [tsdp_pkg::ROW_W-1:0] row,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           rdata
);
  localparam int MW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW = tsdp_pkg::COL_W + tsdp_pkg::ROW_W;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IW-1:0]    idx;
  logic [MW-1:0]    idx_n;
  logic             in_bank;

  assign idx     = {col, row};
  assign idx_n   = MW'(idx);
  assign in_bank = 32'(idx) < 32'(DEPTH);
  assign rdata   = (en && !we && in_bank) ? mem[idx_n] : '0;

  always_ff @(posedge clk)
    if (en && we && in_bank) mem[idx_n] <= wdata;

  // R5: an enabled bank is only ever addressed inside its own rows and columns
  p_bank_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> in_bank);
endmodule

// File: rtl/tsdp_mem.sv
module tsdp_mem #(
  parameter int WORDS = 1152,
  parameter int LANES = 2,
  localparam int WIDTH  = tsdp_pkg::LANE_BITS * LANES,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data
);
  localparam int BANKS = (WORDS + tsdp_pkg::BANK_WORDS - 1) / tsdp_pkg::BANK_WORDS;

  logic              rd_q, wr_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [WIDTH-1:0]  wr_data_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      rd_q      <= rd_en;
      wr_q      <= wr_en;
      rd_addr_q <= rd_addr;
      wr_addr_q <= wr_addr;
      wr_data_q <= wr_data;
    end

  logic                       phase_rd, phase_wr, hit;
  logic [ADDR_W-1:0]          acc_addr;
  logic [BANKS-1:0]           bank_en;
  logic [tsdp_pkg::ROW_W-1:0] row;
  logic [tsdp_pkg::COL_W-1:0] col;
  logic [WIDTH-1:0]           bank_rdata [BANKS];
  logic [WIDTH-1:0]           array_word;

  tsdp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_q), .wr_req(wr_q),
    .rd_addr(rd_addr_q), .wr_addr(wr_addr_q),
    .phase_rd(phase_rd), .phase_wr(phase_wr), .acc_addr(acc_addr)
  );

  tsdp_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W), .BANKS(BANKS)) u_dec (
    .active(phase_rd | phase_wr), .addr(acc_addr), .hit(hit),
    .bank_en(bank_en), .row(row), .col(col)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    tsdp_bank #(.WIDTH(WIDTH), .DEPTH(tsdp_pkg::bank_depth(WORDS, g))) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[g]), .we(phase_wr),
      .col(col), .row(row), .wdata(wr_data_q), .rdata(bank_rdata[g])
    );
  end

  always_comb begin
    array_word = '0;
    for (int b = 0; b < BANKS; b++) array_word |= bank_rdata[b];
  end

  // Output holder: loads at the end of the read phase only
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)        rd_data <= '0;
    else if (phase_rd) rd_data <= array_word;

  // R6: at most one bank is active in the write phase and in the read phase
  p_bank_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  p_rd_bank_onehot_r6: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  // R7: no request in a phase keeps every bank idle
  p_rest_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |-> (bank_en == '0));
  p_rest_rd_r7: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_q |-> (bank_en == '0));
  // R4: a cycle without a read leaves the held word alone
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |-> $stable(rd_data));
  // R9: a read past the end loads zero
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && (32'(rd_addr_q) >= 32'(WORDS))) |-> (rd_data == '0));
endmodule

// File: tb/tsdp_mem_tb.sv
`timescale 1ns/1ps
module tsdp_mem_tb;
  localparam int WORDS  = 1152;
  localparam int LANES  = 2;
  localparam int W      = 9 * LANES;
  localparam int AW     = $clog2(WORDS);
  localparam int ASPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;

  always #2.5 clk = ~clk;

  tsdp_mem #(.WORDS(WORDS), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] mdl [WORDS];
  logic [W-1:0] last = '0;

  function automatic logic [W-1:0] pat(input int a, input int salt);
    return W'(a * 32'h9E37 + salt * 32'h51 + 1);
  endfunction

  function automatic bit in_mem(input int a);
    return a < WORDS;
  endfunction

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One access cycle, entered and left at falling edge + 1 ns.
  task automatic op(input bit rd, input int ra, input bit wr, input int wa,
                    input logic [W-1:0] wd, input string tag);
    logic [W-1:0] exp;
    exp = last;
    if (rd) exp = in_mem(ra) ? mdl[ra] : '0;
    rd_en = rd; rd_addr = AW'(ra);
    wr_en = wr; wr_addr = AW'(wa); wr_data = wd;
    @(posedge clk);
    #1;
    // R1: scramble the inputs after the sampling edge
    rd_en = ~rd; rd_addr = ~AW'(ra);
    wr_en = ~wr; wr_addr = ~AW'(wa); wr_data = ~wd;
    @(negedge clk);
    #1;
    rd_en = 1'b0; wr_en = 1'b0;
    check(rd_data, exp, tag);
    last = exp;
    if (wr && in_mem(wa)) mdl[wa] = wd;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(rd_data, '0, "R10 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rd_data, '0, "R10 after reset");

    // R1: plain write then read
    op(0, 0, 1, 5, pat(5, 1), "R1 write only");
    op(1, 5, 0, 0, '0, "R1 read back");
    // R3: same address in one cycle returns the old word, then the new one
    op(1, 5, 1, 5, pat(5, 2), "R3 same-cycle old word");
    op(1, 5, 0, 0, '0, "R3 new word next cycle");
    // R4 / R7: idle and write-only cycles keep the held word
    op(0, 0, 0, 0, '0, "R7 idle hold");
    op(0, 0, 1, 9, pat(9, 1), "R4 write-only hold");
    // R8 / R9: writes past the end are dropped, reads past the end give zero
    op(0, 0, 1, WORDS + 5, pat(77, 3), "R8 oob write");
    op(1, 5, 0, 0, '0, "R8 alias untouched");
    op(1, WORDS + 5, 0, 0, '0, "R9 oob read zero");
    op(0, 0, 0, 0, '0, "R4 zero held");

    // R2 / R5: fill every word while reading the one before it
    for (int a = 0; a < WORDS; a++)
      op(a > 0, a - 1, 1, a, pat(a, 4), "R2 fill with concurrent read");
    // R5: every address keeps its own word
    for (int a = 0; a < WORDS; a++)
      op(1, a, 0, 0, '0, "R5 readback");
    // Bank boundaries and last word
    op(1, 511, 1, 512, pat(512, 5), "R5 bank edge low");
    op(1, 512, 0, 0, '0, "R5 bank edge high");
    op(1, WORDS - 1, 1, WORDS - 1, pat(1, 6), "R3 last word old");
    op(1, WORDS - 1, 0, 0, '0, "R3 last word new");

    // Random mix, including out-of-range addresses
    for (int i = 0; i < 3000; i++) begin
      bit rd, wr;
      int ra, wa;
      rd = $urandom_range(0, 3) != 0;
      wr = $urandom_range(0, 2) != 0;
      ra = $urandom_range(0, ASPACE - 1);
      wa = ($urandom_range(0, 3) == 0) ? ra : $urandom_range(0, ASPACE - 1);
      op(rd, ra, wr, wa, W'($urandom), "R2 random mix");
    end
    finish_run();
  end
endmodule